// File: doc/BRIEF.md
# System Coprocessor Instruction Executor

This block takes one system-coprocessor instruction word at a time and carries it out. It checks privilege first. In kernel mode, or when the coprocessor-0 enable bit of the status register is set, the instruction is decoded. Otherwise a coprocessor-unusable exception is raised and nothing else happens.

A decoded instruction takes one of several paths:
- Register moves pull a value from the coprocessor register file into a general register, or push a general register into the coprocessor register file. Single-word moves are sign-extended; doubleword moves are not.
- Exception return chooses between the error level and the normal level and redirects the PC.
- Wait holds the PC on the same instruction.
- The four translation-buffer commands (indexed read, indexed write, random write and probe) are passed to an external buffer with a request/acknowledge handshake.

Every accepted instruction ends in a one-cycle `done` pulse. Its effects appear as one-cycle write strobes with their data, in the same cycle as that pulse.

The host offers an instruction with `instr_valid` while `busy` is low. A non-buffer instruction completes in the cycle after it is accepted. A buffer instruction raises `tb_req` and keeps it high until `tb_ack`. The results of an indexed read or a probe appear in the cycle after the acknowledge.

Top module: `cop0_exec_unit`

## Requirements
- R1: When `kernel_mode` is 0 and `sr_cu0` is 0, any accepted instruction produces `exc_cu` and `done` in the next cycle, with no other effect and no buffer request.
- R2: With instruction bit 25 set, the function field (bits 5:0) selects the operation: 0x01 indexed read, 0x02 indexed write, 0x06 random write, 0x08 probe, 0x18 exception return, 0x20 wait. Any other function code gives `done` alone, with no strobe and no exception.
- R3: Exception return with `sr_erl`=1 redirects to `errorepc_in` and pulses `sr_clr_erl`. With `sr_erl`=0 it redirects to `epc_in` and pulses `sr_clr_exl`. Both cases pulse `leave_kernel` and `ll_clear`.
- R4: A probe writes Index. On a miss the value is 0x8000_0000. On a hit it is the zero-extended `tb_hit_idx`.
- R5: The buffer command code on `tb_op` is 0 for indexed read, 1 for indexed write, 2 for random write and 3 for probe. `tb_idx` is taken from `index_sel` for reads and indexed writes, from `random_in` for random writes, and is 0 for a probe.
- R6: With bit 25 clear, rs (bits 25:21) = 0 writes general register rt (bits 20:16) with the coprocessor register rd (bits 15:11) sign-extended from bit 31. rs = 1 writes all 64 bits unchanged.
- R7: rs = 4 writes coprocessor register rd with the general register rt sign-extended from bit 31. rs = 5 writes all 64 bits unchanged.
- R8: rs = 2 and rs = 6 give `done` alone, as does rs = 8 with rt 0 to 3. rs = 8 with rt above 3, or any other rs value, gives `exc_ri`.
- R9: Wait pulses `pc_hold` with `done` and does not redirect the PC.
- R10: An indexed read loads PageMask with the inverted entry mask with bits 12:0 cleared. It loads EntryHi with the entry tag ORed with the 8-bit ASID, with bits 61:40 cleared. It loads both EntryLo words unchanged.
- R11: A buffer command holds `tb_req`, `tb_op` and `tb_idx` steady until `tb_ack`, and `done` follows in the next cycle. `instr_valid` is ignored while `busy` is high. After reset every output strobe, `busy` and `tb_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction offered |
| instr | input | 32 | Instruction word |
| kernel_mode | input | 1 | Processor is in kernel mode |
| sr_cu0 | input | 1 | Status coprocessor-0 enable bit |
| sr_erl | input | 1 | Status error-level bit |
| epc_in | input | XLEN | Exception return address |
| errorepc_in | input | XLEN | Error return address |
| index_sel | input | IDX_W | Low bits of the Index register |
| random_in | input | IDX_W | Current Random register value |
| cp0_raddr | output | 5 | Coprocessor register read address (rd) |
| cp0_rdata | input | XLEN | Coprocessor register read data |
| gpr_raddr | output | 5 | General register read address (rt) |
| gpr_rdata | input | XLEN | General register read data |
| busy | output | 1 | Buffer command outstanding |
| done | output | 1 | Instruction complete |
| gpr_we | output | 1 | General register write strobe |
| gpr_waddr | output | 5 | General register write address |
| gpr_wdata | output | XLEN | General register write data |
| cp0_we | output | 1 | Coprocessor register write strobe |
| cp0_waddr | output | 5 | Coprocessor register write address |
| cp0_wdata | output | XLEN | Coprocessor register write data |
| pc_redirect | output | 1 | Exception return redirect |
| pc_target | output | XLEN | Redirect target |
| pc_hold | output | 1 | Re-execute current instruction |
| sr_clr_erl | output | 1 | Clear status error level |
| sr_clr_exl | output | 1 | Clear status exception level |
| leave_kernel | output | 1 | Leave kernel mode |
| ll_clear | output | 1 | Clear load-linked flag |
| index_we | output | 1 | Index write strobe |
| index_wdata | output | 32 | Index write value |
| tlbr_we | output | 1 | Entry registers write strobe |
| pagemask_wdata | output | XLEN | PageMask value |
| entryhi_wdata | output | XLEN | EntryHi value |
| entrylo0_wdata | output | XLEN | EntryLo0 value |
| entrylo1_wdata | output | XLEN | EntryLo1 value |
| exc_cu | output | 1 | Coprocessor-unusable exception |
| exc_ri | output | 1 | Reserved-instruction exception |
| tb_req | output | 1 | Buffer command request |
| tb_op | output | 2 | Buffer command code |
| tb_idx | output | IDX_W | Buffer entry index |
| tb_ack | input | 1 | Buffer acknowledge |
| tb_hit | input | 1 | Probe found a match |
| tb_hit_idx | input | IDX_W | Index of matching entry |
| tb_mask | input | XLEN | Entry mask |
| tb_tag | input | XLEN | Entry tag |
| tb_asid | input | 8 | Entry address-space id |
| tb_lo0 | input | XLEN | Entry even-page word |
| tb_lo1 | input | XLEN | Entry odd-page word |

## Verification
The assertions check several properties on every cycle:
- An unusable exception never appears alongside another effect, and at most one effect strobe fires at a time.
- Every exception return clears exactly one level bit and also leaves kernel mode and clears the load-linked flag.
- Index values written by a probe are either the miss code or a legal entry number.
- Indexed-read data carries its cleared bit ranges.
- A buffer request stays stable until acknowledged, and `done` follows every acknowledge.

Only the bench scenarios can show the correct data values:
- sign extension against doubleword pass-through;
- which return address is chosen;
- which index source feeds each buffer command;
- the no-effect encodings;
- that an instruction offered while busy is dropped.

// File: rtl/cop0_pkg.sv
package cop0_pkg;
   localparam int unsigned REG_AW = 5;

   typedef enum logic [1:0] {
      TB_READ  = 2'd0,
      TB_WIDX  = 2'd1,
      TB_WRAND = 2'd2,
      TB_PROBE = 2'd3
   } tb_op_e;

   typedef enum logic [3:0] {
      K_NONE, K_CU, K_RI, K_MF, K_DMF, K_MT, K_DMT, K_ERET, K_WAIT, K_TLB
   } kind_e;

   typedef struct packed {
      kind_e  kind;
      tb_op_e op;
   } dec_t;

   localparam logic [5:0] FN_TLBR  = 6'h01;
   localparam logic [5:0] FN_TLBWI = 6'h02;
   localparam logic [5:0] FN_TLBWR = 6'h06;
   localparam logic [5:0] FN_TLBP  = 6'h08;
   localparam logic [5:0] FN_ERET  = 6'h18;
   localparam logic [5:0] FN_WAIT  = 6'h20;

   localparam logic [3:0] RS_MF  = 4'd0;
   localparam logic [3:0] RS_DMF = 4'd1;
   localparam logic [3:0] RS_CF  = 4'd2;
   localparam logic [3:0] RS_MT  = 4'd4;
   localparam logic [3:0] RS_DMT = 4'd5;
   localparam logic [3:0] RS_CT  = 4'd6;
   localparam logic [3:0] RS_BC  = 4'd8;
endpackage

// File: rtl/cop0_decoder.sv
module cop0_decoder
   import cop0_pkg::*;
(
   input  logic       kernel_mode,
   input  logic       sr_cu0,
   input  logic       fmt_bit,
   input  logic [3:0] rs_lo,
   input  logic [2:0] rt_hi,
   input  logic [5:0] funct,
   output dec_t       dec
);
   always_comb begin
      dec.kind = K_NONE;
      dec.op   = TB_READ;
      if (!kernel_mode && !sr_cu0) begin
         dec.kind = K_CU;
      end else if (fmt_bit) begin
         case (funct)
            FN_TLBR:  begin dec.kind = K_TLB; dec.op = TB_READ;  end
            FN_TLBWI: begin dec.kind = K_TLB; dec.op = TB_WIDX;  end
            FN_TLBWR: begin dec.kind = K_TLB; dec.op = TB_WRAND; end
            FN_TLBP:  begin dec.kind = K_TLB; dec.op = TB_PROBE; end
            FN_ERET:  dec.kind = K_ERET;
            FN_WAIT:  dec.kind = K_WAIT;
            default:  dec.kind = K_NONE;
         endcase
      end else begin
         case (rs_lo)
            RS_MF:   dec.kind = K_MF;
            RS_DMF:  dec.kind = K_DMF;
            RS_CF:   dec.kind = K_NONE;
            RS_MT:   dec.kind = K_MT;
            RS_DMT:  dec.kind = K_DMT;
            RS_CT:   dec.kind = K_NONE;
            RS_BC:   dec.kind = (rt_hi == 3'd0) ? K_NONE : K_RI;
            default: dec.kind = K_RI;
         endcase
      end
   end
endmodule

// File: rtl/cop0_seq.sv
module cop0_seq
   import cop0_pkg::*;
#(
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  tb_op_e           op_in,
   input  logic [IDX_W-1:0] idx_in,
   input  logic             tb_ack,
   output logic             tb_req,
   output tb_op_e           tb_op,
   output logic [IDX_W-1:0] tb_idx,
   output logic             fire
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tb_req <= 1'b0;
         tb_op  <= TB_READ;
         tb_idx <= '0;
      end else if (!tb_req && start) begin
         tb_req <= 1'b1;
         tb_op  <= op_in;
         tb_idx <= idx_in;
      end else if (tb_req && tb_ack) begin
         tb_req <= 1'b0;
      end
   end

   assign fire = tb_req & tb_ack;
endmodule

// File: rtl/cop0_result.sv
module cop0_result
   import cop0_pkg::*;
#(
   parameter int unsigned XLEN  = 64,
   parameter int unsigned IDX_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              simple_go,
   input  kind_e             kind,
   input  logic [REG_AW-1:0] rt,
   input  logic [REG_AW-1:0] rd,
   input  logic [XLEN-1:0]   cp0_rdata,
   input  logic [XLEN-1:0]   gpr_rdata,
   input  logic              sr_erl,
   input  logic [XLEN-1:0]   epc_in,
   input  logic [XLEN-1:0]   errorepc_in,
   input  logic              fire,
   input  tb_op_e            fire_op,
   input  logic              tb_hit,
   input  logic [IDX_W-1:0]  tb_hit_idx,
   input  logic [XLEN-1:0]   tb_mask,
   input  logic [XLEN-1:0]   tb_tag,
   input  logic [7:0]        tb_asid,
   input  logic [XLEN-1:0]   tb_lo0,
   input  logic [XLEN-1:0]   tb_lo1,
   output logic              done,
   output logic              gpr_we,
   output logic [REG_AW-1:0] gpr_waddr,
   output logic [XLEN-1:0]   gpr_wdata,
   output logic              cp0_we,
   output logic [REG_AW-1:0] cp0_waddr,
   output logic [XLEN-1:0]   cp0_wdata,
   output logic              pc_redirect,
   output logic [XLEN-1:0]   pc_target,
   output logic              pc_hold,
   output logic              sr_clr_erl,
   output logic              sr_clr_exl,
   output logic              leave_kernel,
   output logic              ll_clear,
   output logic              index_we,
   output logic [31:0]       index_wdata,
   output logic              tlbr_we,
   output logic [XLEN-1:0]   pagemask_wdata,
   output logic [XLEN-1:0]   entryhi_wdata,
   output logic [XLEN-1:0]   entrylo0_wdata,
   output logic [XLEN-1:0]   entrylo1_wdata,
   output logic              exc_cu,
   output logic              exc_ri
);
   localparam int unsigned EXT_W   = XLEN - 32;
   localparam int unsigned HI_LO   = 40;
   localparam int unsigned HI_TOP  = 61;
   localparam int unsigned PM_TOP  = 12;
   localparam logic [31:0] MISS_CODE = 32'h8000_0000;

   logic [XLEN-1:0] hi_keep;
   logic [XLEN-1:0] pm_keep;

   for (genvar b = 0; b < XLEN; b++) begin : g_keep
      assign hi_keep[b] = (b < HI_LO) || (b > HI_TOP);
      assign pm_keep[b] = (b > PM_TOP);
   end

   function automatic logic [XLEN-1:0] sext32(input logic [XLEN-1:0] v);
      return {{EXT_W{v[31]}}, v[31:0]};
   endfunction

   logic [XLEN-1:0] asid_ext;
   assign asid_ext = {{(XLEN-8){1'b0}}, tb_asid};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done           <= 1'b0;
         gpr_we         <= 1'b0;
         gpr_waddr      <= '0;
         gpr_wdata      <= '0;
         cp0_we         <= 1'b0;
         cp0_waddr      <= '0;
         cp0_wdata      <= '0;
         pc_redirect    <= 1'b0;
         pc_target      <= '0;
         pc_hold        <= 1'b0;
         sr_clr_erl     <= 1'b0;
         sr_clr_exl     <= 1'b0;
         leave_kernel   <= 1'b0;
         ll_clear       <= 1'b0;
         index_we       <= 1'b0;
         index_wdata    <= '0;
         tlbr_we        <= 1'b0;
         pagemask_wdata <= '0;
         entryhi_wdata  <= '0;
         entrylo0_wdata <= '0;
         entrylo1_wdata <= '0;
         exc_cu         <= 1'b0;
         exc_ri         <= 1'b0;
      end else begin
         done         <= simple_go | fire;
         gpr_we       <= 1'b0;
         cp0_we       <= 1'b0;
         pc_redirect  <= 1'b0;
         pc_hold      <= 1'b0;
         sr_clr_erl   <= 1'b0;
         sr_clr_exl   <= 1'b0;
         leave_kernel <= 1'b0;
         ll_clear     <= 1'b0;
         index_we     <= 1'b0;
         tlbr_we      <= 1'b0;
         exc_cu       <= 1'b0;
         exc_ri       <= 1'b0;
         if (simple_go) begin
            case (kind)
               K_CU: exc_cu <= 1'b1;
               K_RI: exc_ri <= 1'b1;
               K_MF: begin
                  gpr_we    <= 1'b1;
                  gpr_waddr <= rt;
                  gpr_wdata <= sext32(cp0_rdata);
               end
               K_DMF: begin
                  gpr_we    <= 1'b1;
                  gpr_waddr <= rt;
                  gpr_wdata <= cp0_rdata;
               end
               K_MT: begin
                  cp0_we    <= 1'b1;
                  cp0_waddr <= rd;
                  cp0_wdata <= sext32(gpr_rdata);
               end
               K_DMT: begin
                  cp0_we    <= 1'b1;
                  cp0_waddr <= rd;
                  cp0_wdata <= gpr_rdata;
               end
               K_ERET: begin
                  pc_redirect  <= 1'b1;
                  pc_target    <= sr_erl ? errorepc_in : epc_in;
                  sr_clr_erl   <= sr_erl;
                  sr_clr_exl   <= ~sr_erl;
                  leave_kernel <= 1'b1;
                  ll_clear     <= 1'b1;
               end
               K_WAIT: pc_hold <= 1'b1;
               default: ;
            endcase
         end
         if (fire) begin
            case (fire_op)
               TB_READ: begin
                  tlbr_we        <= 1'b1;
                  pagemask_wdata <= ~tb_mask & pm_keep;
                  entryhi_wdata  <= (tb_tag | asid_ext) & hi_keep;
                  entrylo0_wdata <= tb_lo0;
                  entrylo1_wdata <= tb_lo1;
               end
               TB_PROBE: begin
                  index_we    <= 1'b1;
                  index_wdata <= tb_hit ? {{(32-IDX_W){1'b0}}, tb_hit_idx} : MISS_CODE;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/cop0_exec_unit.sv
module cop0_exec_unit
   import cop0_pkg::*;
#(
   parameter int unsigned XLEN  = 64,
   parameter int unsigned IDX_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [31:0]       instr,
   input  logic              kernel_mode,
   input  logic              sr_cu0,
   input  logic              sr_erl,
   input  logic [XLEN-1:0]   epc_in,
   input  logic [XLEN-1:0]   errorepc_in,
   input  logic [IDX_W-1:0]  index_sel,
   input  logic [IDX_W-1:0]  random_in,
   output logic [4:0]        cp0_raddr,
   input  logic [XLEN-1:0]   cp0_rdata,
   output logic [4:0]        gpr_raddr,
   input  logic [XLEN-1:0]   gpr_rdata,
   output logic              busy,
   output logic              done,
   output logic              gpr_we,
   output logic [4:0]        gpr_waddr,
   output logic [XLEN-1:0]   gpr_wdata,
   output logic              cp0_we,
   output logic [4:0]        cp0_waddr,
   output logic [XLEN-1:0]   cp0_wdata,
   output logic              pc_redirect,
   output logic [XLEN-1:0]   pc_target,
   output logic              pc_hold,
   output logic              sr_clr_erl,
   output logic              sr_clr_exl,
   output logic              leave_kernel,
   output logic              ll_clear,
   output logic              index_we,
   output logic [31:0]       index_wdata,
   output logic              tlbr_we,
   output logic [XLEN-1:0]   pagemask_wdata,
   output logic [XLEN-1:0]   entryhi_wdata,
   output logic [XLEN-1:0]   entrylo0_wdata,
   output logic [XLEN-1:0]   entrylo1_wdata,
   output logic              exc_cu,
   output logic              exc_ri,
   output logic              tb_req,
   output logic [1:0]        tb_op,
   output logic [IDX_W-1:0]  tb_idx,
   input  logic              tb_ack,
   input  logic              tb_hit,
   input  logic [IDX_W-1:0]  tb_hit_idx,
   input  logic [XLEN-1:0]   tb_mask,
   input  logic [XLEN-1:0]   tb_tag,
   input  logic [7:0]        tb_asid,
   input  logic [XLEN-1:0]   tb_lo0,
   input  logic [XLEN-1:0]   tb_lo1
);
   if (XLEN < 64) begin : g_bad_xlen
      $error("cop0_exec_unit: XLEN must be at least 64");
   end
   if (IDX_W < 1 || IDX_W > 31) begin : g_bad_idx
      $error("cop0_exec_unit: IDX_W must lie in 1..31");
   end

   dec_t              dec;
   logic              accept;
   logic              simple_go;
   logic              tlb_start;
   logic [IDX_W-1:0]  idx_pick;
   logic              fire;
   tb_op_e            op_q;
   logic              unused_fields;

   assign unused_fields = ^{instr[31:26], instr[10:6]};
   assign cp0_raddr = instr[15:11];
   assign gpr_raddr = instr[20:16];

   cop0_decoder u_dec (
      .kernel_mode (kernel_mode),
      .sr_cu0      (sr_cu0),
      .fmt_bit     (instr[25]),
      .rs_lo       (instr[24:21]),
      .rt_hi       (instr[20:18]),
      .funct       (instr[5:0]),
      .dec         (dec)
   );

   assign accept    = instr_valid & ~tb_req;
   assign tlb_start = accept & (dec.kind == K_TLB);
   assign simple_go = accept & (dec.kind != K_TLB);
   assign busy      = tb_req;

   always_comb begin
      case (dec.op)
         TB_WRAND: idx_pick = random_in;
         TB_PROBE: idx_pick = '0;
         default:  idx_pick = index_sel;
      endcase
   end

   cop0_seq #(.IDX_W(IDX_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (tlb_start),
      .op_in  (dec.op),
      .idx_in (idx_pick),
      .tb_ack (tb_ack),
      .tb_req (tb_req),
      .tb_op  (op_q),
      .tb_idx (tb_idx),
      .fire   (fire)
   );

   assign tb_op = op_q;

   cop0_result #(.XLEN(XLEN), .IDX_W(IDX_W)) u_res (
      .clk            (clk),
      .rst_n          (rst_n),
      .simple_go      (simple_go),
      .kind           (dec.kind),
      .rt             (instr[20:16]),
      .rd             (instr[15:11]),
      .cp0_rdata      (cp0_rdata),
      .gpr_rdata      (gpr_rdata),
      .sr_erl         (sr_erl),
      .epc_in         (epc_in),
      .errorepc_in    (errorepc_in),
      .fire           (fire),
      .fire_op        (op_q),
      .tb_hit         (tb_hit),
      .tb_hit_idx     (tb_hit_idx),
      .tb_mask        (tb_mask),
      .tb_tag         (tb_tag),
      .tb_asid        (tb_asid),
      .tb_lo0         (tb_lo0),
      .tb_lo1         (tb_lo1),
      .done           (done),
      .gpr_we         (gpr_we),
      .gpr_waddr      (gpr_waddr),
      .gpr_wdata      (gpr_wdata),
      .cp0_we         (cp0_we),
      .cp0_waddr      (cp0_waddr),
      .cp0_wdata      (cp0_wdata),
      .pc_redirect    (pc_redirect),
      .pc_target      (pc_target),
      .pc_hold        (pc_hold),
      .sr_clr_erl     (sr_clr_erl),
      .sr_clr_exl     (sr_clr_exl),
      .leave_kernel   (leave_kernel),
      .ll_clear       (ll_clear),
      .index_we       (index_we),
      .index_wdata    (index_wdata),
      .tlbr_we        (tlbr_we),
      .pagemask_wdata (pagemask_wdata),
      .entryhi_wdata  (entryhi_wdata),
      .entrylo0_wdata (entrylo0_wdata),
      .entrylo1_wdata (entrylo1_wdata),
      .exc_cu         (exc_cu),
      .exc_ri         (exc_ri)
   );
endmodule

// File: rtl/cop0_exec_chk.sv
module cop0_exec_chk #(
   parameter int unsigned XLEN  = 64,
   parameter int unsigned IDX_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             done,
   input logic             gpr_we,
   input logic             cp0_we,
   input logic             pc_redirect,
   input logic             pc_hold,
   input logic             sr_clr_erl,
   input logic             sr_clr_exl,
   input logic             leave_kernel,
   input logic             ll_clear,
   input logic             index_we,
   input logic [31:0]      index_wdata,
   input logic             tlbr_we,
   input logic [XLEN-1:0]  pagemask_wdata,
   input logic [XLEN-1:0]  entryhi_wdata,
   input logic             exc_cu,
   input logic             exc_ri,
   input logic             tb_req,
   input logic [1:0]       tb_op,
   input logic [IDX_W-1:0] tb_idx,
   input logic             tb_ack
);
   assert_cu_alone_R1: assert property (@(posedge clk) disable iff (!rst_n)
      exc_cu |-> (done && !gpr_we && !cp0_we && !pc_redirect && !pc_hold &&
                  !index_we && !tlbr_we && !exc_ri && !tb_req));

   assert_one_effect_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gpr_we, cp0_we, pc_redirect, pc_hold, index_we, tlbr_we, exc_cu, exc_ri}));

   assert_eret_levels_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pc_redirect |-> (leave_kernel && ll_clear && (sr_clr_erl != sr_clr_exl) && done));

   assert_probe_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      index_we |-> ((index_wdata == 32'h8000_0000) || (index_wdata[31:IDX_W] == '0)));

   assert_ri_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_ri |-> done);

   assert_wait_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pc_hold |-> (done && !pc_redirect));

   assert_read_fields_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tlbr_we |-> ((pagemask_wdata[12:0] == '0) && (entryhi_wdata[61:40] == '0)));

   assert_req_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (tb_req && !tb_ack) |=> (tb_req && $stable(tb_op) && $stable(tb_idx)));

   assert_ack_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (tb_req && tb_ack) |=> (done && !tb_req));
endmodule

bind cop0_exec_unit cop0_exec_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_cop0_exec_unit.sv
module sim_cop0_exec_unit;
   localparam int XLEN = 64;
   localparam int IW   = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            instr_valid = 1'b0;
   logic [31:0]     instr = '0;
   logic            kernel_mode = 1'b1;
   logic            sr_cu0 = 1'b0;
   logic            sr_erl = 1'b0;
   logic [63:0]     epc_in = 64'h0000_0000_8000_0180;
   logic [63:0]     errorepc_in = 64'hFFFF_FFFF_BFC0_0380;
   logic [IW-1:0]   index_sel = '0;
   logic [IW-1:0]   random_in = '0;
   logic [4:0]      cp0_raddr, gpr_raddr;
   logic [63:0]     cp0_rdata;
   logic [63:0]     gpr_rdata = '0;
   logic            busy, done, gpr_we, cp0_we, pc_redirect, pc_hold;
   logic [4:0]      gpr_waddr, cp0_waddr;
   logic [63:0]     gpr_wdata, cp0_wdata, pc_target;
   logic            sr_clr_erl, sr_clr_exl, leave_kernel, ll_clear;
   logic            index_we, tlbr_we, exc_cu, exc_ri, tb_req;
   logic [31:0]     index_wdata;
   logic [63:0]     pagemask_wdata, entryhi_wdata, entrylo0_wdata, entrylo1_wdata;
   logic [1:0]      tb_op;
   logic [IW-1:0]   tb_idx;
   logic            tb_ack = 1'b0;
   logic            tb_hit = 1'b0;
   logic [IW-1:0]   tb_hit_idx = '0;
   logic [63:0]     tb_mask = '0, tb_tag = '0, tb_lo0 = '0, tb_lo1 = '0;
   logic [7:0]      tb_asid = '0;

   int checks = 0;
   int errors = 0;
   int ack_lat = 0;
   int lat_cnt = 0;
   logic probe_hit = 1'b0;
   logic [IW-1:0] probe_idx = '0;

   always #10 clk = ~clk;

   assign cp0_rdata = {24'h5A5A5A, 3'b000, cp0_raddr,
                       (cp0_raddr[0] ? 32'h8765_4321 : 32'h1234_5678)};

   cop0_exec_unit #(.XLEN(XLEN), .IDX_W(IW)) u0 (.*);

   // buffer responder
   always @(negedge clk) begin
      if (tb_req && !tb_ack) begin
         if (lat_cnt >= ack_lat) begin
            tb_ack     = 1'b1;
            lat_cnt    = 0;
            tb_hit     = probe_hit;
            tb_hit_idx = probe_idx;
            tb_mask    = 64'h0000_0000_01FF_E000 ^ {58'd0, tb_idx};
            tb_tag     = 64'hC000_00FF_FFFF_E000 | ({58'd0, tb_idx} << 16);
            tb_asid    = 8'h30 + 8'(tb_idx);
            tb_lo0     = 64'h0000_0000_0123_4567 + 64'(tb_idx);
            tb_lo1     = 64'hFFFF_0000_0765_4321 - 64'(tb_idx);
         end else begin
            lat_cnt = lat_cnt + 1;
         end
      end else begin
         tb_ack = 1'b0;
      end
   end

   // reference model
   logic        e_busy = 0, e_done = 0, e_gwe = 0, e_cwe = 0, e_redir = 0, e_hold = 0;
   logic        e_cerl = 0, e_cexl = 0, e_lk = 0, e_ll = 0, e_iwe = 0, e_rwe = 0, e_cu = 0, e_ri = 0;
   logic [1:0]  e_op = 0;
   logic [IW-1:0] e_idx = 0;
   logic [4:0]  e_gaddr = 0, e_caddr = 0;
   logic [63:0] e_gdata = 0, e_cdata = 0, e_pc = 0, e_pm = 0, e_hi = 0, e_l0 = 0, e_l1 = 0;
   logic [31:0] e_index = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         e_busy = 0; e_done = 0; e_gwe = 0; e_cwe = 0; e_redir = 0; e_hold = 0;
         e_cerl = 0; e_cexl = 0; e_lk = 0; e_ll = 0; e_iwe = 0; e_rwe = 0; e_cu = 0; e_ri = 0;
      end else begin
         e_done = 0; e_gwe = 0; e_cwe = 0; e_redir = 0; e_hold = 0;
         e_cerl = 0; e_cexl = 0; e_lk = 0; e_ll = 0; e_iwe = 0; e_rwe = 0; e_cu = 0; e_ri = 0;
         if (e_busy) begin
            if (tb_ack) begin
               e_busy = 0;
               e_done = 1;
               if (e_op == 2'd0) begin
                  e_rwe = 1;
                  e_pm  = (~tb_mask >> 13) << 13;
                  e_hi  = (tb_tag | {56'd0, tb_asid});
                  for (int b = 40; b <= 61; b++) e_hi[b] = 1'b0;
                  e_l0  = tb_lo0;
                  e_l1  = tb_lo1;
               end else if (e_op == 2'd3) begin
                  e_iwe   = 1;
                  e_index = tb_hit ? 32'(tb_hit_idx) : (32'd1 << 31);
               end
            end
         end else if (instr_valid) begin
            if (!kernel_mode && !sr_cu0) begin
               e_cu = 1; e_done = 1;
            end else if (instr[25]) begin
               case (instr[5:0])
                  6'd1:  begin e_busy = 1; e_op = 2'd0; e_idx = index_sel; end
                  6'd2:  begin e_busy = 1; e_op = 2'd1; e_idx = index_sel; end
                  6'd6:  begin e_busy = 1; e_op = 2'd2; e_idx = random_in; end
                  6'd8:  begin e_busy = 1; e_op = 2'd3; e_idx = 0; end
                  6'd24: begin
                     e_done = 1; e_redir = 1; e_lk = 1; e_ll = 1;
                     if (sr_erl) begin e_pc = errorepc_in; e_cerl = 1; end
                     else begin e_pc = epc_in; e_cexl = 1; end
                  end
                  6'd32: begin e_done = 1; e_hold = 1; end
                  default: e_done = 1;
               endcase
            end else begin
               e_done = 1;
               case (instr[25:21])
                  5'd0: begin e_gwe = 1; e_gaddr = instr[20:16]; e_gdata = 64'($signed(cp0_rdata[31:0])); end
                  5'd1: begin e_gwe = 1; e_gaddr = instr[20:16]; e_gdata = cp0_rdata; end
                  5'd4: begin e_cwe = 1; e_caddr = instr[15:11]; e_cdata = 64'($signed(gpr_rdata[31:0])); end
                  5'd5: begin e_cwe = 1; e_caddr = instr[15:11]; e_cdata = gpr_rdata; end
                  5'd2, 5'd6: ;
                  5'd8: if (instr[20:16] > 5'd3) e_ri = 1;
                  default: e_ri = 1;
               endcase
            end
         end
      end
   end

   task automatic cmp(input string tag, input string nm, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, nm, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         cmp("R11", "done", 64'(done), 64'(e_done));
         cmp("R11", "busy", 64'(busy), 64'(e_busy));
         cmp("R11", "tb_req", 64'(tb_req), 64'(e_busy));
         if (e_busy) begin
            cmp("R5", "tb_op", 64'(tb_op), 64'(e_op));
            cmp("R5", "tb_idx", 64'(tb_idx), 64'(e_idx));
         end
         cmp("R1", "exc_cu", 64'(exc_cu), 64'(e_cu));
         cmp("R8", "exc_ri", 64'(exc_ri), 64'(e_ri));
         cmp("R6", "gpr_we", 64'(gpr_we), 64'(e_gwe));
         if (e_gwe) begin
            cmp("R6", "gpr_waddr", 64'(gpr_waddr), 64'(e_gaddr));
            cmp("R6", "gpr_wdata", gpr_wdata, e_gdata);
         end
         cmp("R7", "cp0_we", 64'(cp0_we), 64'(e_cwe));
         if (e_cwe) begin
            cmp("R7", "cp0_waddr", 64'(cp0_waddr), 64'(e_caddr));
            cmp("R7", "cp0_wdata", cp0_wdata, e_cdata);
         end
         cmp("R3", "pc_redirect", 64'(pc_redirect), 64'(e_redir));
         cmp("R3", "sr_clr_erl", 64'(sr_clr_erl), 64'(e_cerl));
         cmp("R3", "sr_clr_exl", 64'(sr_clr_exl), 64'(e_cexl));
         cmp("R3", "leave_kernel", 64'(leave_kernel), 64'(e_lk));
         cmp("R3", "ll_clear", 64'(ll_clear), 64'(e_ll));
         if (e_redir) cmp("R3", "pc_target", pc_target, e_pc);
         cmp("R9", "pc_hold", 64'(pc_hold), 64'(e_hold));
         cmp("R4", "index_we", 64'(index_we), 64'(e_iwe));
         if (e_iwe) cmp("R4", "index_wdata", 64'(index_wdata), 64'(e_index));
         cmp("R10", "tlbr_we", 64'(tlbr_we), 64'(e_rwe));
         if (e_rwe) begin
            cmp("R10", "pagemask", pagemask_wdata, e_pm);
            cmp("R10", "entryhi", entryhi_wdata, e_hi);
            cmp("R10", "entrylo0", entrylo0_wdata, e_l0);
            cmp("R10", "entrylo1", entrylo1_wdata, e_l1);
         end
      end
   end

   function automatic logic [31:0] fn_word(input logic [5:0] f);
      return 32'h4200_0000 | {26'd0, f};
   endfunction

   function automatic logic [31:0] mv_word(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd);
      return {6'h10, rs, rt, rd, 11'd0};
   endfunction

   task automatic issue(input logic [31:0] w);
      @(negedge clk);
      instr = w;
      instr_valid = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   initial begin
      #(20 * 20000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state R11
      cmp("R11", "reset busy", 64'(busy), 64'd0);
      cmp("R11", "reset done", 64'(done), 64'd0);
      cmp("R11", "reset tb_req", 64'(tb_req), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R6 moves from
      issue(mv_word(5'd0, 5'd3, 5'd13));
      issue(mv_word(5'd0, 5'd4, 5'd12));
      issue(mv_word(5'd1, 5'd7, 5'd13));
      // R7 moves to
      gpr_rdata = 64'h1111_2222_9ABC_DEF0;
      issue(mv_word(5'd4, 5'd2, 5'd9));
      issue(mv_word(5'd5, 5'd2, 5'd14));
      gpr_rdata = 64'hFFFF_0000_7000_0001;
      issue(mv_word(5'd4, 5'd2, 5'd10));
      // R8 no-effect and reserved encodings
      issue(mv_word(5'd2, 5'd1, 5'd1));
      issue(mv_word(5'd6, 5'd1, 5'd1));
      for (int r = 0; r < 4; r++) issue(mv_word(5'd8, 5'(r), 5'd0));
      issue(mv_word(5'd8, 5'd5, 5'd0));
      issue(mv_word(5'd3, 5'd0, 5'd0));
      issue(mv_word(5'd9, 5'd0, 5'd0));
      // R1 unusable, then enabled user access
      kernel_mode = 1'b0;
      sr_cu0 = 1'b0;
      issue(mv_word(5'd0, 5'd3, 5'd13));
      issue(fn_word(6'h01));
      sr_cu0 = 1'b1;
      issue(mv_word(5'd1, 5'd3, 5'd13));
      kernel_mode = 1'b1;
      sr_cu0 = 1'b0;
      // R3 exception return both levels
      sr_erl = 1'b1;
      issue(fn_word(6'h18));
      sr_erl = 1'b0;
      issue(fn_word(6'h18));
      // R9 wait
      issue(fn_word(6'h20));
      // R2 unknown function code: done alone
      @(negedge clk);
      instr = fn_word(6'h3F);
      instr_valid = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0;
      cmp("R2", "unknown funct done", 64'(done), 64'd1);
      cmp("R2", "unknown funct effects",
          64'({gpr_we, cp0_we, pc_redirect, pc_hold, index_we, tlbr_we, exc_cu, exc_ri, tb_req}), 64'd0);
      repeat (3) @(negedge clk);
      // R5 / R10 buffer commands with varied latency
      index_sel = 6'd5;
      random_in = 6'd37;
      ack_lat = 0;
      issue(fn_word(6'h01));
      ack_lat = 2;
      index_sel = 6'd44;
      issue(fn_word(6'h01));
      issue(fn_word(6'h02));
      ack_lat = 1;
      issue(fn_word(6'h06));
      // R4 probe hit and miss
      probe_hit = 1'b1;
      probe_idx = 6'd17;
      issue(fn_word(6'h08));
      probe_hit = 1'b0;
      issue(fn_word(6'h08));
      // R11 instruction offered while busy is dropped
      ack_lat = 3;
      @(negedge clk);
      instr = fn_word(6'h02);
      instr_valid = 1'b1;
      @(negedge clk);
      instr = mv_word(5'd1, 5'd6, 5'd13);
      @(negedge clk);
      cmp("R11", "busy while offered", 64'(busy), 64'd1);
      instr_valid = 1'b0;
      repeat (8) @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule